// File: doc/BRIEF.md
# Linked-descriptor DMA channel fetcher

This block is the control half of a single DMA channel. Software first programs a descriptor pointer and then sets the channel's run bit. From that point the block works on its own. It reads a six-word descriptor from memory, one word at a time, through a request/response read port. It splits the packed configuration word into a source half and a destination half, and it hands the decoded fields, the two addresses and the byte count to an external data mover through a one-cycle start strobe.

While the mover reports beats, the block keeps running copies of the source address, the destination address and the bytes still to go. Software can read these through an eight-entry register window. When the mover signals completion, the block pulses a per-descriptor event. It then either fetches the descriptor named by the link word, or stops when the link word holds the terminator value 0xFFFFF800. On stopping it clears the run bit and pulses an end-of-chain event.

A pause bit holds the channel at a safe point, and writing zero to the run bit aborts it. Moving the data and arbitrating the bus are left to the neighbouring blocks.

Top module: `dma_chain_fetcher`

## Requirements
- R1: A write of 1 to register index 0 while the channel is stopped latches the pointer from index 2 and starts fetching. Index 0 bit 0 then reads 1 from the very next cycle until the chain ends or software writes 0.
- R2: Descriptor word k (k = 0..5) is read from pointer + 4k, in order. Only one request is outstanding at a time, and mem_req and mem_addr are held until a cycle with mem_rvalid high.
- R3: Word order is: configuration, source address, destination address, byte count, parameter, link. After the link word the block raises mv_start for exactly one cycle. Bits 15:0 of the configuration word drive the source fields and bits 31:16 drive the destination fields. Within each half, bits 4:0 are the request line, 6:5 the address mode, 8:7 the burst code and 10:9 the width code. mv_wait carries parameter bits 7:0 and mv_blk carries bits 15:8.
- R4: On each accepted beat, the current source (index 4) and current destination (index 5) each grow by mv_beat_bytes when their address mode is 0. For any other mode they stay unchanged.
- R5: Bytes-left (index 6) loads the descriptor byte count and drops by mv_beat_bytes on each beat, never going below 0.
- R6: pkg_done pulses one cycle after mv_done for every descriptor. If the link equals 0xFFFFF800, queue_done pulses in the same cycle and the run bit reads 0. Otherwise the next fetch starts at the link address.
- R7: half_done pulses once per descriptor, one cycle after the first beat that leaves 2*bytes-left at or below the byte count.
- R8: While pause (index 1 bit 0) is 1, no new descriptor fetch starts (mem_req stays 0 at word 0) and mv_start stays 0. When pause returns to 0 the channel continues where it stopped.
- R9: A write of 0 to index 0 stops the channel at the next edge. The run bit then reads 0, and no further request or start is issued.
- R10: reg_rdata shows, by index, the following: 0 run, 1 pause, 2 pointer, 3 configuration, 4 source, 5 destination, 6 bytes left, 7 parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| mv_start | output | 1 | One-cycle mover start |
| mv_src_addr | output | 32 | Source start address |
| mv_dst_addr | output | 32 | Destination start address |
| mv_len | output | 32 | Byte count |
| mv_src_drq | output | 5 | Source request line |
| mv_src_mode | output | 2 | Source address mode |
| mv_src_burst | output | 2 | Source burst code |
| mv_src_width | output | 2 | Source width code |
| mv_dst_drq | output | 5 | Destination request line |
| mv_dst_mode | output | 2 | Destination address mode |
| mv_dst_burst | output | 2 | Destination burst code |
| mv_dst_width | output | 2 | Destination width code |
| mv_wait | output | 8 | Wait-cycle count |
| mv_blk | output | 8 | Data block size |
| mv_beat | input | 1 | Mover moved one beat |
| mv_beat_bytes | input | BB_W | Bytes in this beat |
| mv_done | input | 1 | Mover finished the descriptor |
| pkg_done | output | 1 | Descriptor finished pulse |
| half_done | output | 1 | Half of descriptor moved pulse |
| queue_done | output | 1 | Chain finished pulse |

## Verification
A wrong word counter or pointer appears on mem_addr in the very cycle of the faulty request. A mis-split configuration word shows on the mover fields in the single start cycle. Wrong arithmetic on the running address or byte counters appears on the rotating register readback within eight cycles of the beat that caused it. A bad chain decision is visible one cycle after mv_done, as a missing or extra end-of-chain pulse or as a run bit still set.

// File: rtl/dma_chain_fetcher.sv
module dma_chain_fetcher #(
  parameter int BB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_idx,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_rvalid,
  input  logic [31:0]     mem_rdata,
  output logic            mv_start,
  output logic [31:0]     mv_src_addr,
  output logic [31:0]     mv_dst_addr,
  output logic [31:0]     mv_len,
  output logic [4:0]      mv_src_drq,
  output logic [1:0]      mv_src_mode,
  output logic [1:0]      mv_src_burst,
  output logic [1:0]      mv_src_width,
  output logic [4:0]      mv_dst_drq,
  output logic [1:0]      mv_dst_mode,
  output logic [1:0]      mv_dst_burst,
  output logic [1:0]      mv_dst_width,
  output logic [7:0]      mv_wait,
  output logic [7:0]      mv_blk,
  input  logic            mv_beat,
  input  logic [BB_W-1:0] mv_beat_bytes,
  input  logic            mv_done,
  output logic            pkg_done,
  output logic            half_done,
  output logic            queue_done
);
  localparam logic [31:0] LINK_END = 32'hFFFF_F800;
  localparam int          WORDS    = 6;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE, S_MOVE} st_t;

  st_t         st;
  logic        run, hold;
  logic [2:0]  k;
  logic [31:0] ptr_reg, ptr, cfg, src, dst, cnt, left, prm, link;
  logic        half_seen;

  logic        run_wr, accept;
  logic [31:0] step, nl;

  assign run_wr   = reg_wr && reg_idx == 3'd0;
  assign mem_req  = st == S_FETCH && !(hold && k == 3'd0);
  assign mem_addr = ptr + {27'd0, k, 2'b00};
  assign accept   = mem_req && mem_rvalid;
  assign mv_start = st == S_ISSUE && !hold;
  assign step     = {{(32-BB_W){1'b0}}, mv_beat_bytes};
  assign nl       = left >= step ? left - step : 32'd0;

  assign mv_src_addr  = src;
  assign mv_dst_addr  = dst;
  assign mv_len       = cnt;
  assign mv_src_drq   = cfg[4:0];
  assign mv_src_mode  = cfg[6:5];
  assign mv_src_burst = cfg[8:7];
  assign mv_src_width = cfg[10:9];
  assign mv_dst_drq   = cfg[20:16];
  assign mv_dst_mode  = cfg[22:21];
  assign mv_dst_burst = cfg[24:23];
  assign mv_dst_width = cfg[26:25];
  assign mv_wait      = prm[7:0];
  assign mv_blk       = prm[15:8];

  always_comb begin
    case (reg_idx)
      3'd0:    reg_rdata = {31'd0, run};
      3'd1:    reg_rdata = {31'd0, hold};
      3'd2:    reg_rdata = ptr_reg;
      3'd3:    reg_rdata = cfg;
      3'd4:    reg_rdata = src;
      3'd5:    reg_rdata = dst;
      3'd6:    reg_rdata = left;
      default: reg_rdata = prm;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; run <= 1'b0; hold <= 1'b0; k <= 3'd0;
      ptr_reg <= '0; ptr <= '0; cfg <= '0; src <= '0; dst <= '0;
      cnt <= '0; left <= '0; prm <= '0; link <= '0; half_seen <= 1'b0;
      pkg_done <= 1'b0; half_done <= 1'b0; queue_done <= 1'b0;
    end else begin
      pkg_done <= 1'b0; half_done <= 1'b0; queue_done <= 1'b0;
      if (reg_wr && reg_idx == 3'd1) hold <= reg_wdata[0];
      if (reg_wr && reg_idx == 3'd2) ptr_reg <= reg_wdata;
      if (run_wr && !reg_wdata[0]) begin
        run <= 1'b0; st <= S_IDLE;
      end else if (run_wr && !run) begin
        run <= 1'b1; st <= S_FETCH; ptr <= ptr_reg; k <= 3'd0;
      end else begin
        case (st)
          S_FETCH: if (accept) begin
            case (k)
              3'd0: cfg <= mem_rdata;
              3'd1: src <= mem_rdata;
              3'd2: dst <= mem_rdata;
              3'd3: begin cnt <= mem_rdata; left <= mem_rdata; half_seen <= 1'b0; end
              3'd4: prm <= mem_rdata;
              default: link <= mem_rdata;
            endcase
            k <= k + 3'd1;
            if (k == 3'(WORDS-1)) st <= S_ISSUE;
          end
          S_ISSUE: if (!hold) st <= S_MOVE;
          S_MOVE: begin
            if (mv_beat) begin
              left <= nl;
              if (cfg[6:5] == 2'd0) src <= src + step;
              if (cfg[22:21] == 2'd0) dst <= dst + step;
              if (!half_seen && {nl, 1'b0} <= {1'b0, cnt}) begin
                half_done <= 1'b1; half_seen <= 1'b1;
              end
            end
            if (mv_done) begin
              pkg_done <= 1'b1;
              if (link == LINK_END) begin
                queue_done <= 1'b1; run <= 1'b0; st <= S_IDLE;
              end else begin
                ptr <= link; k <= 3'd0; st <= S_FETCH;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> $stable(mem_addr));
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);
  assert_left_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_MOVE && $past(st == S_MOVE) |-> left <= $past(left));
  assert_end_clears_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    queue_done |-> !run && pkg_done);
  assert_half_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |=> !half_done);
  assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mem_req && !mv_start);
endmodule

// File: tb/sim_dma_chain_fetcher.sv
module sim_dma_chain_fetcher;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic reg_wr = 0; logic [2:0] reg_idx = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata, mem_addr, mv_src_addr, mv_dst_addr, mv_len;
  logic mem_req, mem_rvalid = 0, mv_start, pkg_done, half_done, queue_done;
  logic [31:0] mem_rdata;
  logic [4:0] mv_src_drq, mv_dst_drq;
  logic [1:0] mv_src_mode, mv_src_burst, mv_src_width, mv_dst_mode, mv_dst_burst, mv_dst_width;
  logic [7:0] mv_wait, mv_blk, mv_beat_bytes = 0;
  logic mv_beat = 0, mv_done = 0;

  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_addr[7:2]];

  dma_chain_fetcher u0 (.*);

  int compared = 0, mismatched = 0, cyc = 0, beat_sz = 4, n_pkg = 0, n_half = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference
  int ph = 0, k = 0;
  bit m_run = 0, m_hold = 0, m_seen = 0, e_pkg = 0, e_half = 0, e_q = 0;
  logic [31:0] m_reg_ptr = 0, m_ptr = 0, w [6], m_src = 0, m_dst = 0, m_left = 0;
  bit mv_act = 0; int mv_rem = 0, mv_dly = 0;

  function automatic bit exp_req(); return ph == 1 && !(m_hold && k == 0); endfunction
  function automatic bit exp_start(); return ph == 2 && !m_hold; endfunction
  function automatic logic [31:0] exp_rd(logic [2:0] i);
    case (i)
      0: return {31'd0, m_run};
      1: return {31'd0, m_hold};
      2: return m_reg_ptr;
      3: return w[0];
      4: return m_src;
      5: return m_dst;
      6: return m_left;
      default: return w[4];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; k = 0; m_run = 0; m_hold = 0; m_reg_ptr = 0; m_ptr = 0;
      foreach (w[i]) w[i] = 0;
      m_src = 0; m_dst = 0; m_left = 0; m_seen = 0; e_pkg = 0; e_half = 0; e_q = 0;
    end else begin
      bit rq, st, nh;
      rq = exp_req(); st = exp_start(); nh = m_hold;
      e_pkg = 0; e_half = 0; e_q = 0;
      if (reg_wr && reg_idx == 1) nh = reg_wdata[0];
      if (reg_wr && reg_idx == 2) m_reg_ptr = reg_wdata;
      if (reg_wr && reg_idx == 0 && !reg_wdata[0]) begin m_run = 0; ph = 0; end
      else if (reg_wr && reg_idx == 0 && !m_run) begin m_run = 1; ph = 1; k = 0; m_ptr = m_reg_ptr; end
      else if (ph == 1) begin
        if (rq && mem_rvalid) begin
          w[k] = mem_rdata;
          if (k == 1) m_src = mem_rdata;
          if (k == 2) m_dst = mem_rdata;
          if (k == 3) begin m_left = mem_rdata; m_seen = 0; end
          k++;
          if (k == 6) ph = 2;
        end
      end else if (ph == 2) begin
        if (st) begin ph = 3; mv_act = 1; mv_rem = w[3]; mv_dly = 2; end
      end else if (ph == 3) begin
        if (mv_beat) begin
          longint nl;
          nl = (m_left >= mv_beat_bytes) ? longint'(m_left) - mv_beat_bytes : 0;
          m_left = nl[31:0];
          if (w[0][6:5] == 0) m_src += mv_beat_bytes;
          if (w[0][22:21] == 0) m_dst += mv_beat_bytes;
          if (!m_seen && 2 * nl <= longint'(w[3])) begin e_half = 1; m_seen = 1; end
        end
        if (mv_done) begin
          e_pkg = 1;
          if (w[5] == 32'hFFFF_F800) begin e_q = 1; m_run = 0; ph = 0; end
          else begin m_ptr = w[5]; k = 0; ph = 1; end
        end
      end
      m_hold = nh;
    end
  end

  // memory response pattern and mover model, driven away from the edge
  always @(negedge clk) begin
    cyc++;
    mem_rvalid = (cyc % 3) != 1;
    mv_beat = 0; mv_done = 0;
    if (mv_act) begin
      if (mv_dly > 0) mv_dly--;
      else if (mv_rem > 0) begin
        int b; b = mv_rem < beat_sz ? mv_rem : beat_sz;
        mv_beat = 1; mv_beat_bytes = 8'(b); mv_rem -= b;
      end else begin mv_done = 1; mv_act = 0; end
    end
  end

  // per-cycle comparison
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R2 req", {31'd0, mem_req}, {31'd0, exp_req()});
      if (exp_req()) chk("R2 addr", mem_addr, m_ptr + 32'(4 * k));
      chk("R8 start", {31'd0, mv_start}, {31'd0, exp_start()});
      if (exp_start()) begin
        chk("R3 src", mv_src_addr, w[1]);
        chk("R3 dst", mv_dst_addr, w[2]);
        chk("R3 len", mv_len, w[3]);
        chk("R3 srcfld", {mv_src_width, mv_src_burst, mv_src_mode, mv_src_drq}, {21'd0, w[0][10:0]});
        chk("R3 dstfld", {mv_dst_width, mv_dst_burst, mv_dst_mode, mv_dst_drq}, {21'd0, w[0][26:16]});
        chk("R3 prm", {mv_blk, mv_wait}, {16'd0, w[4][15:0]});
      end
      chk("R6 pkg", {31'd0, pkg_done}, {31'd0, e_pkg});
      chk("R6 queue", {31'd0, queue_done}, {31'd0, e_q});
      chk("R7 half", {31'd0, half_done}, {31'd0, e_half});
      chk("R10 read", reg_rdata, exp_rd(reg_idx));
      n_pkg += pkg_done; n_half += half_done;
    end
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wr(logic [2:0] i, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic idle(int n);
    repeat (n) begin @(negedge clk); reg_idx = reg_idx + 3'd1; end
  endtask
  task automatic rd(logic [2:0] i, logic [31:0] e, string tag);
    @(negedge clk); reg_idx = i; #1 chk(tag, reg_rdata, e);
  endtask
  task automatic wait_phase(int p);
    for (int i = 0; i < 3000 && ph != p; i++) idle(1);
  endtask
  task automatic wait_end();
    for (int i = 0; i < 3000 && m_run; i++) idle(1);
    idle(4);
  endtask
  task automatic put(int base, logic [31:0] c, s, d, n, p, nx);
    int b; b = (base - 'h1000) / 4;
    mem[b] = c; mem[b+1] = s; mem[b+2] = d; mem[b+3] = n; mem[b+4] = p; mem[b+5] = nx;
  endtask

  initial begin
    foreach (mem[i]) mem[i] = 0;
    put('h1000, 32'h052B_0481, 32'h2000, 32'h3000, 32, 32'h0000_0A05, 32'hFFFF_F800);
    put('h1040, 32'h0001_03A5, 32'h4000, 32'h5000, 20, 32'h0000_1020, 32'h1080);
    put('h1080, 32'h0681_07FF, 32'h6000, 32'h7000, 7, 32'h1234_FF01, 32'h10C0);
    put('h10C0, 32'h0000_0000, 32'h8000, 32'h9000, 0, 32'h0, 32'hFFFF_F800);
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 0, "R1 reset run"); chk("R1 reset req", {31'd0, mem_req}, 0);
    rd(6, 0, "R5 reset left");

    // single descriptor, linear source, fixed destination
    beat_sz = 4;
    wr(2, 32'h1000); wr(0, 1);
    rd(0, 1, "R1 run after start");
    wait_end();
    rd(4, 32'h2000 + 32, "R4 linear source");
    rd(5, 32'h3000, "R4 fixed destination");
    rd(6, 0, "R5 left empty");
    rd(0, 0, "R6 run cleared");
    chk("R6 one pkg", n_pkg, 1); chk("R7 one half", n_half, 1);

    // three-descriptor chain, odd beat size, zero-length tail
    beat_sz = 3; n_pkg = 0; n_half = 0;
    wr(2, 32'h1040); wr(0, 1);
    wr(0, 1);
    wait_end();
    chk("R6 three pkg", n_pkg, 3); chk("R7 two half", n_half, 2);
    rd(3, 32'h0, "R10 last config");

    // pause before start, then pause mid-chain
    wr(1, 1); wr(0, 1); idle(6);
    chk("R8 no fetch paused", {31'd0, mem_req}, 0);
    wr(1, 0);
    wait_phase(3); wr(1, 1);
    wait_phase(1); idle(8);
    chk("R8 held at link", {31'd0, mem_req}, 0);
    rd(1, 1, "R8 pause reads");
    wr(1, 0);
    wait_end();
    rd(0, 0, "R8 resumed to end");

    // abort mid-move
    wr(0, 1); wait_phase(3); wr(0, 0);
    rd(0, 0, "R9 run zero"); idle(30);
    chk("R9 no request", {31'd0, mem_req}, 0);
    chk("R9 no start", {31'd0, mv_start}, 0);
    idle(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule